// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block answers on a two-wire serial bus as a 256-byte EEPROM. It runs on a fast system clock and samples the bus clock and data lines through synchronizers. It finds START and STOP conditions from the sampled lines and then decodes the select byte. A byte only concerns this device when its upper nibble is the memory type code and its next three bits equal the three strap inputs. The strap inputs let eight such devices share one bus. The storage is an internal register file, and every byte reads 0xFF after reset.

A controller writes by sending the select byte with the direction bit clear, then a word address, then up to eight data bytes. The data bytes are held in a burst buffer. STOP or a repeated START writes them into the array and starts a programming period, during which the busy flag is high and select bytes get no acknowledge. The programming period lasts twice as long when the burst covers two 8-byte rows. A controller reads either from the current address or, after a dummy write of the word address, through a repeated START. The address moves forward after each byte that the controller acknowledges. The device changes its data-line drive only while the clock is low, and only after a fixed delay that follows the falling edge.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the data-line pull is released, busy is low, the current address is 0 and every byte reads 0xFF.
- R2: The device acknowledges a select byte (first bit received is bit 7) only when bits 7..4 are 1010 and bits 3..1 equal `chip_sel_i`. For any other select byte it leaves the data line released until the next START, and that includes the acknowledge clocks of the bytes that follow.
- R3: Bit 0 of the select byte sets the direction: 1 reads and 0 writes.
- R4: A write of one data byte ending in STOP stores the byte at the word address, and busy stays high for exactly PROG_CYCLES system clocks.
- R5: The data bytes of one write go to consecutive addresses, modulo 256. At most 8 bytes are acknowledged. Later bytes get no acknowledge and are discarded. The accepted bytes are committed at STOP or at a repeated START.
- R6: When the first and last committed addresses differ in bits 7..3, busy stays high for 2*PROG_CYCLES clocks. Otherwise it stays high for PROG_CYCLES clocks.
- R7: While busy is high the device does not acknowledge its select byte.
- R8: A write of only a word address followed by a repeated START and a read select returns the byte at that address.
- R9: In a read, the address increments after each byte the controller acknowledges. A byte that is not acknowledged ends the read and does not advance the address, so the next current-address read returns that same byte again. The address wraps from 255 to 0.
- R10: The pull enable changes only while SCL is low, and no sooner than OUT_DLY system clocks after SCL falls.
- R11: A write that carries no data byte sets the current address and starts no programming period.
- R12: After a write, the current address equals the word address plus the number of accepted data bytes, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed, including this device's own pull |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |
| chip_sel_i | input | 3 | Strap inputs compared with select bits 3..1 |
| busy_o | output | 1 | High during the modelled programming period |

## Verification
The bench sweeps every strap value against the matching select code, a code with one strap bit flipped and a wrong type code. A decoder that compares the wrong bits would acknowledge a neighbour's address or stay silent to its own. It writes bursts that stay in one row, cross into the next row and run past eight bytes. A wrong row test would give the wrong busy length, and a missing burst cap would overwrite a ninth byte or acknowledge it. It also commits a write at a repeated START and then confirms the busy NACK. A full 256-byte sequential read, which ends in a NACK and is followed by a current-address read, exposes any address that advances on a NACK or fails to wrap. A monitor watches every pull transition against the bench's own SCL, so a device that drives on the rising edge, or too soon after the falling edge, is caught.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_ADDR,
    ST_ADDRACK,
    ST_WDATA,
    ST_WDACK,
    ST_RDATA,
    ST_RACK
  } eep_state_t;

  localparam logic [3:0] MEM_TYPE_CODE = 4'b1010;

  // Select byte decode: type nibble plus three strap bits.
  function automatic logic sel_match(input logic [7:0] sel_byte, input logic [2:0] straps);
    return (sel_byte[7:4] == MEM_TYPE_CODE) && (sel_byte[3:1] == straps);
  endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [2:0] scl_pipe;
  logic [2:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 3'b111;
      sda_pipe <= 3'b111;
    end else begin
      scl_pipe <= {scl_pipe[1:0], scl_i};
      sda_pipe <= {sda_pipe[1:0], sda_i};
    end
  end

  logic scl_q;
  logic sda_q;

  assign scl_s = scl_pipe[1];
  assign sda_s = sda_pipe[1];
  assign scl_q = scl_pipe[2];
  assign sda_q = sda_pipe[2];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic double_i,
  output logic busy_o
);

  localparam int CW = $clog2(2 * PROG_CYCLES + 1);

  function automatic logic [CW-1:0] prog_len(input logic dbl);
    return dbl ? CW'(2 * PROG_CYCLES) : CW'(PROG_CYCLES);
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= prog_len(double_i);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/eep_wbuf.sv
module eep_wbuf #(
  parameter int ADDR_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int BURST    = 1 << ROW_BITS,
  parameter int CNT_W    = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  input  logic              commit_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              commit_evt_o,
  output logic              span_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o
);

  // Row of the first byte against row of the last byte of the burst.
  function automatic logic crosses_row(input logic [ADDR_W-1:0] base, input logic [CNT_W-1:0] n);
    logic [ADDR_W-1:0] last;
    last = base + ADDR_W'(n) - 1'b1;
    return base[ADDR_W-1:ROW_BITS] != last[ADDR_W-1:ROW_BITS];
  endfunction

  logic [7:0]        buf_q [BURST];
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;

  assign full_o       = (cnt_q == CNT_W'(BURST));
  assign commit_evt_o = commit_i && (cnt_q != '0);
  assign span_o       = crosses_row(base_q, cnt_q);
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk) begin
    if (push_i && !full_o) begin
      buf_q[cnt_q[ROW_BITS-1:0]] <= push_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      idx_q  <= '0;
    end else begin
      if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        idx_q  <= idx_q + 1'b1;
      end
      if (clear_i) begin
        base_q <= base_i;
        cnt_q  <= '0;
      end else if (push_i && !full_o) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (commit_evt_o) begin
        left_q <= cnt_q;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end
  end

  // One array write per cycle while the programming period runs.
  assign mem_we_o    = (left_q != '0);
  assign mem_waddr_o = base_q + ADDR_W'(idx_q);
  assign mem_wdata_o = buf_q[idx_q[ROW_BITS-1:0]];

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] INIT   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= INIT;
      end
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int ROW_BITS    = 3,
  parameter int PROG_CYCLES = 2_000_000,
  parameter int OUT_DLY     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] chip_sel_i,
  output logic       busy_o
);

  localparam int BURST = 1 << ROW_BITS;
  localparam int CNT_W = $clog2(BURST + 1);
  localparam int DLY_W = $clog2(OUT_DLY + 1);

  // Bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  eep_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_state_t        st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              rw_q;
  logic              mst_nack;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        rd_byte;
  logic              pend;
  logic              pull;
  logic [DLY_W-1:0]  dly;

  // Named internal events
  logic in_dev, in_devack;
  logic sel_done, sel_ok, addr_done, data_done, data_push, commit_req;
  logic commit_evt, span, wb_full;
  logic [CNT_W-1:0] wb_cnt;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0] mem_wdata, rdata;

  assign in_dev     = (st == ST_DEV);
  assign in_devack  = (st == ST_DEVACK);
  assign sel_done   = scl_fall && in_dev && (bitcnt == 4'd8);
  assign sel_ok     = sel_done && sel_match(shreg, chip_sel_i) && !busy_o;
  assign addr_done  = scl_fall && (st == ST_ADDR) && (bitcnt == 4'd8);
  assign data_done  = scl_fall && (st == ST_WDATA) && (bitcnt == 4'd8);
  assign data_push  = data_done && !wb_full;
  assign commit_req = start_evt | stop_evt;

  eep_wbuf #(
    .ADDR_W   (ADDR_W),
    .ROW_BITS (ROW_BITS),
    .BURST    (BURST),
    .CNT_W    (CNT_W)
  ) u_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (addr_done),
    .base_i       (shreg[ADDR_W-1:0]),
    .push_i       (data_push),
    .push_data_i  (shreg),
    .commit_i     (commit_req),
    .cnt_o        (wb_cnt),
    .full_o       (wb_full),
    .commit_evt_o (commit_evt),
    .span_o       (span),
    .mem_we_o     (mem_we),
    .mem_waddr_o  (mem_waddr),
    .mem_wdata_o  (mem_wdata)
  );

  eep_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (commit_evt),
    .double_i (span),
    .busy_o   (busy_o)
  );

  eep_store #(
    .ADDR_W (ADDR_W),
    .INIT   (8'hFF)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (cur_addr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      mst_nack <= 1'b1;
      cur_addr <= '0;
      rd_byte  <= '0;
      pend     <= 1'b0;
      pull     <= 1'b0;
      dly      <= '0;
    end else begin
      // Delayed output update, away from the falling edge
      if (dly != '0) begin
        dly <= dly - 1'b1;
        if (dly == DLY_W'(1)) pull <= pend;
      end

      if (start_evt) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        pull   <= 1'b0;
        dly    <= '0;
      end else if (stop_evt) begin
        st   <= ST_IDLE;
        pull <= 1'b0;
        dly  <= '0;
      end else if (scl_rise) begin
        case (st)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_RDATA: begin
            if (bitcnt != 4'd8) bitcnt <= bitcnt + 1'b1;
          end
          ST_RACK: begin
            mst_nack <= sda_s;
            if (!sda_s) cur_addr <= cur_addr + 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && (st != ST_IDLE)) begin
        dly  <= DLY_W'(OUT_DLY);
        pend <= 1'b0;
        case (st)
          ST_DEV: begin
            if (bitcnt == 4'd8) begin
              if (sel_ok) begin
                st   <= ST_DEVACK;
                rw_q <= shreg[0];
                pend <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_DEVACK: begin
            bitcnt <= '0;
            if (rw_q) begin
              st      <= ST_RDATA;
              rd_byte <= rdata;
              pend    <= ~rdata[7];
            end else begin
              st <= ST_ADDR;
            end
          end
          ST_ADDR: begin
            if (bitcnt == 4'd8) begin
              st       <= ST_ADDRACK;
              cur_addr <= shreg[ADDR_W-1:0];
              pend     <= 1'b1;
            end
          end
          ST_ADDRACK: begin
            st     <= ST_WDATA;
            bitcnt <= '0;
          end
          ST_WDATA: begin
            if (bitcnt == 4'd8) begin
              st <= ST_WDACK;
              if (!wb_full) begin
                cur_addr <= cur_addr + 1'b1;
                pend     <= 1'b1;
              end
            end
          end
          ST_WDACK: begin
            st     <= ST_WDATA;
            bitcnt <= '0;
          end
          ST_RDATA: begin
            if (bitcnt == 4'd8) st <= ST_RACK;
            else                pend <= ~rd_byte[3'd7 - bitcnt[2:0]];
          end
          ST_RACK: begin
            if (!mst_nack) begin
              st      <= ST_RDATA;
              bitcnt  <= '0;
              rd_byte <= rdata;
              pend    <= ~rdata[7];
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;

endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BURST = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_pull,
  input logic             busy,
  input logic             commit_evt,
  input logic             in_dev,
  input logic             in_devack,
  input logic [7:0]       shreg,
  input logic [2:0]       chip_sel,
  input logic             start_evt,
  input logic [3:0]       bitcnt,
  input logic [CNT_W-1:0] wcnt
);

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_devack) |-> sel_match(shreg, chip_sel));

  a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_devack) |-> !busy);

  a_r6_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_evt));

  a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CNT_W'(BURST));

  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (in_dev && bitcnt == 4'd0));

endmodule

bind i2c_eeprom_target eep_checker #(
  .CNT_W (CNT_W),
  .BURST (BURST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_pull   (sda_pull_o),
  .busy       (busy_o),
  .commit_evt (commit_evt),
  .in_dev     (in_dev),
  .in_devack  (in_devack),
  .shreg      (shreg),
  .chip_sel   (chip_sel_i),
  .start_evt  (start_evt),
  .bitcnt     (bitcnt),
  .wcnt       (wb_cnt)
);

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;

  localparam int PROG  = 600;
  localparam int ODLY  = 4;
  localparam int Q     = 8;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       pull;
  logic       busy;
  logic [2:0] straps = 3'b110;
  logic       sda_line;

  assign sda_line = sda_drv & ~pull;

  always #2.5 clk = ~clk;

  i2c_eeprom_target #(
    .ADDR_W (8), .ROW_BITS (3), .PROG_CYCLES (PROG), .OUT_DLY (ODLY)
  ) dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_drv), .sda_i (sda_line),
    .sda_pull_o (pull), .chip_sel_i (straps), .busy_o (busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [256];
  int exp_cur = 0;

  // Monitors: busy run length, drive timing
  int run_len = 0, last_len = 0, since_fall = 0, viol = 0, cycles = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    cycles++;
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    if (prev_scl && !scl_drv) since_fall = 0; else since_fall++;
    if (rst_n && pull != prev_pull && (scl_drv || since_fall < ODLY)) viol++;
    prev_pull = pull;
    prev_scl = scl_drv;
    if (cycles > LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    w(Q); sda_drv = 1'b0; w(Q); scl_drv = 1'b0;
  endtask

  task automatic brstart();
    w(Q); sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q); sda_drv = 1'b0; w(Q); scl_drv = 1'b0;
  endtask

  task automatic bstop();
    w(Q); sda_drv = 1'b0; w(Q); scl_drv = 1'b1; w(Q); sda_drv = 1'b1; w(Q);
  endtask

  task automatic bit_io(input logic b, output logic s);
    w(Q); sda_drv = b; w(Q); scl_drv = 1'b1; w(Q); s = sda_line; w(Q); scl_drv = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(~give_ack, s);
  endtask

  function automatic logic [7:0] sel_code(input int straps_v, input int rd);
    return 8'((10 << 4) + (straps_v << 1) + rd);
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 7 + seed) % 256);
  endfunction

  function automatic int prog_expect(input int base, input int n);
    return ((base / 8) != (((base + n - 1) % 256) / 8)) ? 2 * PROG : PROG;
  endfunction

  task automatic wait_idle();
    w(4);
    while (busy) w(1);
    w(2);
  endtask

  // Write burst; checks acks; returns with STOP sent
  task automatic write_burst(input int base, input int n, input int seed, input string tag);
    logic ack;
    bstart();
    send(sel_code(int'(straps), 0), ack);
    check(ack, {tag, " select ack"}, ack, 1);
    send(8'(base), ack);
    check(ack, {tag, " address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send(pat(base + i, seed), ack);
      check(ack == (i < 8), {tag, " data ack"}, ack, (i < 8));
      if (i < 8) model[(base + i) % 256] = pat(base + i, seed);
    end
    exp_cur = (base + (n < 8 ? n : 8)) % 256;
    bstop();
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bstart();
    send(sel_code(int'(straps), 1), ack);
    check(ack, {tag, " read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      check(b == model[exp_cur], tag, b, model[exp_cur]);
      if (i != n - 1) exp_cur = (exp_cur + 1) % 256;
    end
    bstop();
  endtask

  task automatic rand_read(input int a, input int n, input string tag);
    logic ack;
    bstart();
    send(sel_code(int'(straps), 0), ack);
    check(ack, {tag, " select ack"}, ack, 1);
    send(8'(a), ack);
    check(ack, {tag, " address ack"}, ack, 1);
    exp_cur = a;
    brstart();
    begin
      logic [7:0] b;
      send(sel_code(int'(straps), 1), ack);
      check(ack, {tag, " read select ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
        recv(i != n - 1, b);
        check(b == model[exp_cur], tag, b, model[exp_cur]);
        if (i != n - 1) exp_cur = (exp_cur + 1) % 256;
      end
    end
    bstop();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    w(5);
    rst_n = 1'b1;
    w(3);
    // R1: reset state
    check(pull == 1'b0, "R1 pull released", pull, 0);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    cur_read(2, "R1 R3 reset contents from address 0");

    // R2: select decode sweep over all straps
    for (int s = 0; s < 8; s++) begin
      straps = 3'(s);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] code;
        logic exp_ack;
        code = (k == 0) ? sel_code(s, 0) :
               (k == 1) ? sel_code(s ^ 2, 0) : 8'((11 << 4) + (s << 1));
        exp_ack = (code[7:4] == 4'd10) && (int'(code[3:1]) == s);
        bstart();
        send(code, ack);
        check(ack == exp_ack, "R2 select decode", ack, exp_ack);
        if (!exp_ack) begin
          send(8'h00, ack);
          check(!ack, "R2 silent until START", ack, 0);
        end
        bstop();
      end
    end
    straps = 3'b110;

    // R4, R7: single byte write and busy NACK
    write_burst(8'h10, 1, 3, "R4 byte write");
    bstart();
    send(sel_code(int'(straps), 0), ack);
    check(!ack, "R7 no ack while busy", ack, 0);
    check(busy, "R7 busy high", busy, 1);
    bstop();
    wait_idle();
    check(last_len == PROG, "R4 programming time", last_len, PROG);

    // R5, R6: one-row burst
    write_burst(8'h20, 8, 11, "R5 burst");
    wait_idle();
    check(last_len == prog_expect(8'h20, 8), "R6 single row time", last_len, prog_expect(8'h20, 8));

    // R6: burst across two rows
    write_burst(8'h1D, 5, 29, "R6 span burst");
    wait_idle();
    check(last_len == prog_expect(8'h1D, 5), "R6 doubled time", last_len, prog_expect(8'h1D, 5));

    // R5: overflow beyond eight bytes
    write_burst(8'h40, 10, 77, "R5 overflow");
    wait_idle();
    check(last_len == PROG, "R5 overflow time", last_len, PROG);
    rand_read(8'h46, 3, "R5 burst cap contents");

    // R11: address-only write
    last_len = 0;
    bstart();
    send(sel_code(int'(straps), 0), ack);
    send(8'h1E, ack);
    bstop();
    exp_cur = 8'h1E;
    w(20);
    check(!busy && last_len == 0, "R11 no programming", last_len, 0);
    cur_read(2, "R11 current address set");

    // R12: current address after a write
    write_burst(8'h1B, 2, 5, "R12 write");
    wait_idle();
    cur_read(1, "R12 address after write");

    // R5: commit at repeated START, R8 random read
    bstart();
    send(sel_code(int'(straps), 0), ack);
    send(8'h80, ack);
    send(8'h3C, ack);
    model[8'h80] = 8'h3C;
    brstart();
    send(sel_code(int'(straps), 1), ack);
    check(!ack, "R5 commit at repeated START", ack, 0);
    bstop();
    wait_idle();
    rand_read(8'h80, 1, "R8 random read");

    // R9: full sequential read with wrap, then current read repeats last byte
    rand_read(0, 256, "R9 sequential sweep");
    check(exp_cur == 255, "R9 final address", exp_cur, 255);
    cur_read(1, "R9 no advance on NACK");
    rand_read(8'hFF, 2, "R9 wrap to 0");

    // R10: drive timing
    check(viol == 0, "R10 drive only while SCL low after delay", viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule